// File: doc/BRIEF.md
# Gated-Clock Flip-Flop State Replication Cell

This block moves the live contents of working flip-flops into spare flip-flops while the surrounding logic keeps running. Each flip-flop is updated only when its clock enable is high. A shared step sequencer walks every cell through the same hand-over. First it links the spare to a small transfer path. Next it holds a capture enable so the spare takes the stored value. It then joins the two enables and the two outputs. Last, it cuts the old flip-flop loose and raises a done flag.

A functional write can arrive while the copy is running. In that case the spare loads the same new value on the same clock edge as the working flip-flop, so the write is never lost. The transfer path carries the stored value when the enable is low and the incoming value when the enable is high.

When a hand-over finishes, the spare becomes the working flip-flop. The retired one then serves as the spare for the next start. A parameter builds the capture-timing register as a transparent latch instead of an edge-triggered flop. This variant suits latch-based circuits.

Top module: `ff_state_replicator`

## Requirements
- R1: After reset every merged output is 0, done is 0, coherent is 1, and the sequencer sits idle with bypass and capture both low.
- R2: If the functional enable stays low for the whole hand-over, the merged output after done equals the value held before start. The spare receives the stored value through the transfer multiplexer.
- R3: At every clock edge where a cell's enable is high, that cell's merged output takes the logic input value on that edge. When the enable is low the output holds. This holds before, during and after a hand-over, so no write is lost.
- R4: From the cycle after capture ends until the outputs of the old flip-flop are cut, the working and spare states of every cell are identical, and the coherent output stays 1.
- R5: Capture stays asserted for max(3, hold_cycles) clock cycles. A hold_cycles value below 3 gives 3.
- R6: The joined-output phase lasts max(1, overlap_cycles) cycles. A value of 0 gives 1.
- R7: done rises exactly max(3,hold_cycles) + max(1,overlap_cycles) + 7 clock edges after the edge that accepts start.
- R8: A start seen while a hand-over is running is ignored. done stays high until the next start, which is accepted from the idle or done state.
- R9: The sequencer raises bypass at least one cycle before capture, drops capture while bypass is still high, and lowers bypass only after capture is low.
- R10: Each of the NCELL cells keeps its own enable and data bit. The bits never mix.
- R11: With USE_LATCH set, the capture-timing register is a latch. Merged output, done timing and coherency are the same as in the flop build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a hand-over (ignored while busy) |
| hold_cycles | input | CNT_W | Requested capture length, floor 3 |
| overlap_cycles | input | CNT_W | Requested joined-output length, floor 1 |
| func_en | input | NCELL | Functional clock enable, one per cell |
| logic_in | input | NCELL | Next-state logic value, one per cell |
| merged_q | output | NCELL | State seen by the circuit, one per cell |
| done | output | 1 | Hand-over complete, held until the next start |
| coherent | output | 1 | Working and spare states agree inside the check window |

## Verification
Hand-overs are run with three enable patterns. With enables held low, only a real copy through the transfer multiplexer can keep the state. With enables held high, every edge is a live write, so any edge where the spare misses an update shows up. With random per-cell enables, stored values and live writes mix across all phases and cells. The extreme count settings (0 clamped to the minimums, plus larger values) separate correct length clamping from wrong clamping through the done latency. A stray start mid-run would show up as a changed latency. A second instance built with the latch option is compared against the same expected values.

// File: rtl/repl_pkg.sv
package repl_pkg;
  localparam int MIN_HOLD    = 3;
  localparam int MIN_OVERLAP = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROUTE, ST_CAPTURE, ST_CC_OFF, ST_BYP_OFF, ST_EN_JOIN,
    ST_AID_OFF, ST_OUT_JOIN, ST_OUT_CUT, ST_IN_CUT, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic bypass;     // spare D taken from transfer mux
    logic cc_cmd;     // capture command before the timing register
    logic linked;     // spare follows functional enable
    logic src_live;   // working flop still has its inputs
    logic out_on_dst; // circuit reads the spare
    logic chk_win;    // states must agree
    logic side;       // 0: flop A works, 1: flop B works
  } repl_ctrl_t;
endpackage

// File: rtl/repl_sequencer.sv
module repl_sequencer
  import repl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic [CNT_W-1:0] overlap_cycles,
  output repl_ctrl_t       ctrl,
  output logic             done
);
  localparam logic [CNT_W-1:0] HOLD_FLOOR = CNT_W'(MIN_HOLD);
  localparam logic [CNT_W-1:0] OVL_FLOOR  = CNT_W'(MIN_OVERLAP);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hold_eff, ovl_eff;
  logic             side_q;
  logic             cnt_zero;
  logic             busy;

  always_comb begin
    hold_eff = (hold_cycles < HOLD_FLOOR) ? HOLD_FLOOR : hold_cycles;
    ovl_eff  = (overlap_cycles < OVL_FLOOR) ? OVL_FLOOR : overlap_cycles;
    cnt_zero = (cnt_q == '0);
    busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_ROUTE;
      ST_ROUTE:    state_d = ST_CAPTURE;
      ST_CAPTURE:  if (cnt_zero) state_d = ST_CC_OFF;
      ST_CC_OFF:   state_d = ST_BYP_OFF;
      ST_BYP_OFF:  state_d = ST_EN_JOIN;
      ST_EN_JOIN:  state_d = ST_AID_OFF;
      ST_AID_OFF:  state_d = ST_OUT_JOIN;
      ST_OUT_JOIN: if (cnt_zero) state_d = ST_OUT_CUT;
      ST_OUT_CUT:  state_d = ST_IN_CUT;
      ST_IN_CUT:   state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      side_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ROUTE)        cnt_q <= hold_eff - 1'b1;
      else if (state_q == ST_AID_OFF) cnt_q <= ovl_eff - 1'b1;
      else if (!cnt_zero)             cnt_q <= cnt_q - 1'b1;
      if (state_q == ST_IN_CUT) side_q <= ~side_q;
    end
  end

  always_comb begin
    ctrl.bypass     = (state_q == ST_ROUTE) || (state_q == ST_CAPTURE) ||
                      (state_q == ST_CC_OFF);
    ctrl.cc_cmd     = (state_q == ST_CAPTURE);
    ctrl.linked     = busy;
    ctrl.src_live   = (state_q != ST_IN_CUT);
    ctrl.out_on_dst = (state_q == ST_OUT_CUT) || (state_q == ST_IN_CUT);
    ctrl.chk_win    = (state_q == ST_CC_OFF) || (state_q == ST_BYP_OFF) ||
                      (state_q == ST_EN_JOIN) || (state_q == ST_AID_OFF) ||
                      (state_q == ST_OUT_JOIN) || (state_q == ST_OUT_CUT);
    ctrl.side       = side_q;
    done            = (state_q == ST_DONE);
  end

  // R9
  cc_after_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.cc_cmd) |-> $past(ctrl.bypass));
  // R9
  bypass_after_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.bypass) |-> $past(!ctrl.cc_cmd));
  // R5
  capture_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.cc_cmd) |-> ($past(ctrl.cc_cmd, 2) && $past(ctrl.cc_cmd, 3)));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (state_q != ST_ROUTE));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/repl_xfer_reg.sv
module repl_xfer_reg #(
  parameter bit USE_LATCH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (USE_LATCH) begin : g_latch
      always_latch begin
        if (!rst_n)   q = 1'b0;
        else if (!clk) q = d;
      end
    end else begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/repl_cell.sv
module repl_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic func_en,
  input  logic logic_in,
  input  logic bypass,
  input  logic cc_en,
  input  logic linked,
  input  logic src_live,
  input  logic out_on_dst,
  input  logic chk_win,
  input  logic side,
  output logic merged,
  output logic match
);
  logic a_q, b_q;
  logic src_q, dst_q;
  logic aid_mux, dst_d, dst_en, src_en;
  logic a_en, a_d, b_en, b_d;

  always_comb begin
    src_q   = side ? b_q : a_q;
    dst_q   = side ? a_q : b_q;
    aid_mux = func_en ? logic_in : src_q;
    dst_d   = bypass ? aid_mux : logic_in;
    dst_en  = cc_en | (func_en & linked);
    src_en  = func_en & src_live;
    a_en    = side ? dst_en : src_en;
    a_d     = side ? dst_d : logic_in;
    b_en    = side ? src_en : dst_en;
    b_d     = side ? logic_in : dst_d;
    merged  = out_on_dst ? dst_q : src_q;
    match   = (a_q == b_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  // R4
  state_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_win |-> (a_q == b_q));
endmodule

// File: rtl/ff_state_replicator.sv
module ff_state_replicator
  import repl_pkg::*;
#(
  parameter int NCELL     = 4,
  parameter int CNT_W     = 8,
  parameter bit USE_LATCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic [CNT_W-1:0] overlap_cycles,
  input  logic [NCELL-1:0] func_en,
  input  logic [NCELL-1:0] logic_in,
  output logic [NCELL-1:0] merged_q,
  output logic             done,
  output logic             coherent
);
  repl_ctrl_t       ctrl;
  logic             cc_eff;
  logic [NCELL-1:0] match;

  repl_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .hold_cycles(hold_cycles), .overlap_cycles(overlap_cycles),
    .ctrl(ctrl), .done(done)
  );

  repl_xfer_reg #(.USE_LATCH(USE_LATCH)) u_xfer (
    .clk(clk), .rst_n(rst_n), .d(ctrl.cc_cmd), .q(cc_eff)
  );

  generate
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      repl_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .func_en(func_en[i]), .logic_in(logic_in[i]),
        .bypass(ctrl.bypass), .cc_en(cc_eff), .linked(ctrl.linked),
        .src_live(ctrl.src_live), .out_on_dst(ctrl.out_on_dst),
        .chk_win(ctrl.chk_win), .side(ctrl.side),
        .merged(merged_q[i]), .match(match[i])
      );
    end
  endgenerate

  assign coherent = !ctrl.chk_win || (&match);

  // R3
  no_lost_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en != '0) |=> (((merged_q ^ $past(logic_in)) & $past(func_en)) == '0));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en == '0) |=> $stable(merged_q));
endmodule

// File: tb/ff_state_replicator_bench.sv
module ff_state_replicator_bench;
  localparam int NCELL = 4;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] hold_cycles = '0;
  logic [CNT_W-1:0] overlap_cycles = '0;
  logic [NCELL-1:0] func_en = '0;
  logic [NCELL-1:0] logic_in = '0;
  logic [NCELL-1:0] merged_q, merged_l;
  logic             done, done_l, coherent, coherent_l;
  logic [NCELL-1:0] exp_q;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  ff_state_replicator #(.NCELL(NCELL), .CNT_W(CNT_W), .USE_LATCH(1'b0)) u_ff_state_replicator (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_cycles(hold_cycles),
    .overlap_cycles(overlap_cycles), .func_en(func_en), .logic_in(logic_in),
    .merged_q(merged_q), .done(done), .coherent(coherent)
  );

  ff_state_replicator #(.NCELL(NCELL), .CNT_W(CNT_W), .USE_LATCH(1'b1)) u_ff_state_replicator_latch (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_cycles(hold_cycles),
    .overlap_cycles(overlap_cycles), .func_en(func_en), .logic_in(logic_in),
    .merged_q(merged_l), .done(done_l), .coherent(coherent_l)
  );

  function automatic logic [NCELL-1:0] next_state(input logic [NCELL-1:0] cur,
      input logic [NCELL-1:0] en, input logic [NCELL-1:0] d);
    return (cur & ~en) | (d & en);
  endfunction

  function automatic int expect_latency(input int h, input int o);
    int he, oe;
    he = (h < 3) ? 3 : h;
    oe = (o < 1) ? 1 : o;
    return he + oe + 7;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= '0;
    else        exp_q <= next_state(exp_q, func_en, logic_in);
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_outputs();
    check(merged_q == exp_q, "R3 merged output", int'(merged_q), int'(exp_q));
    check(merged_l == exp_q, "R11 latch build merged output", int'(merged_l), int'(exp_q));
    check(coherent == 1'b1, "R4 coherent flag", int'(coherent), 1);
    check(coherent_l == 1'b1, "R4 R11 coherent flag latch build", int'(coherent_l), 1);
    check(done_l == done, "R11 latch build done", int'(done_l), int'(done));
  endtask

  task automatic tick();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic drive_data(input int mode);
    logic_in = NCELL'($urandom);
    case (mode)
      0:       func_en = '0;
      1:       func_en = '1;
      default: func_en = NCELL'($urandom);
    endcase
  endtask

  task automatic do_run(input int h, input int o, input int mode);
    int n;
    logic [NCELL-1:0] snap;
    @(negedge clk);
    hold_cycles    = CNT_W'(h);
    overlap_cycles = CNT_W'(o);
    start = 1'b1;
    drive_data(mode);
    tick();
    start = 1'b0;
    snap = exp_q;
    check(done == 1'b0, "R8 done cleared after accepted start", int'(done), 0);
    n = 0;
    while (!done && n < 400) begin
      drive_data(mode);
      start = (n == 4);  // R8: stray start inside the run
      tick();
      n++;
    end
    start = 1'b0;
    check(n == expect_latency(h, o), "R5 R6 R7 done latency", n, expect_latency(h, o));
    if (mode == 0)
      check(merged_q == snap, "R2 R9 stored state copied", int'(merged_q), int'(snap));
    for (int i = 0; i < NCELL; i++)
      check(merged_q[i] == exp_q[i], "R10 per-cell state", int'(merged_q[i]), int'(exp_q[i]));
    for (int k = 0; k < 3; k++) begin
      drive_data(2);
      tick();
      check(done == 1'b1, "R8 done held until next start", int'(done), 1);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(merged_q == '0, "R1 reset merged", int'(merged_q), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(coherent == 1'b1, "R1 reset coherent", int'(coherent), 1);
    rst_n = 1'b1;
    tick();
    check(merged_q == '0, "R1 merged after release", int'(merged_q), 0);
    for (int k = 0; k < 8; k++) begin
      drive_data(2);
      tick();
    end
    do_run(0, 0, 0);   // minima clamp, pure copy
    do_run(3, 1, 1);   // every edge a live write
    do_run(5, 2, 2);   // mixed
    do_run(1, 4, 0);   // copy back into the first flop
    do_run(2, 0, 1);
    for (int r = 0; r < 8; r++)
      do_run($urandom_range(0, 9), $urandom_range(0, 6), $urandom_range(0, 2));
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule